// File: doc/BRIEF.md
# Framebuffer Copy and Fill Blitter

This block moves or paints short horizontal runs of pixels inside an 8-bit-per-pixel frame memory. A host drives it through a write-only register window. A write with address bit 2 low loads a holding register, and the low byte of that register is the paint colour. A write with address bit 2 high launches an operation. That launch write carries the destination pixel address in its bus address. Its data word carries a source pixel address and a run length. A source of all ones selects a fill. Any other source value selects a copy.

The engine reaches the frame memory through a synchronous port with one read channel and one write channel, and it handles one pixel per cycle. During a copy, the read of each source pixel is issued one cycle ahead of the write of its destination pixel. A forwarding path keeps the ascending, pixel-after-pixel result intact when the source and destination runs overlap. When a run ends, the block pulses a modified-region report that gives the destination start and the run length. `busy` tells the host when the engine is free to take a new launch.

Top module: `fb_blit_engine`

## Requirements
- R1: A host write with `bus_addr[2]` = 0 loads `bus_wdata[7:0]` as the paint colour. It leaves the frame memory untouched and `busy` low.
- R2: A host write with `bus_addr[2]` = 1 while `busy` is low starts an operation, and `busy` is high in the following cycle.
- R3: The destination pixel address of an operation is `bus_addr[22:3]`.
- R4: The run length is `bus_wdata[28:24]` + 1, which covers 1 to 32 pixels. `bus_wdata[31:29]` has no effect.
- R5: A source field `bus_wdata[23:0]` of 24'hFFFFFF means fill. Every pixel of the run receives the colour that was held when the operation started. A colour write made while the engine is busy does not change a fill already running.
- R6: Any other source field means copy from pixel address `bus_wdata[19:0]`, taken in ascending order. The result equals copying one pixel at a time, so with destination = source + 1 every pixel takes the value of the first source pixel. A field with only the low 20 bits set is a copy.
- R7: A launch write that arrives while `busy` is high is ignored. It writes no pixel and produces no report.
- R8: `bus_rdata` always reads as zero.
- R9: One cycle after the last pixel write, `dirty_valid` pulses for one cycle. `dirty_start` then gives the destination address and `dirty_len` gives the run length.
- R10: Source and destination addresses wrap modulo 2^20, and no error is raised.
- R11: `busy` stays high for N cycles for a fill of N pixels and for N+1 cycles for a copy of N pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 24 | Host byte address within the window |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, always zero |
| busy | output | 1 | Operation in progress |
| mem_rd_en | output | 1 | Frame memory read enable |
| mem_raddr | output | 20 | Frame memory read pixel address |
| mem_rdata | input | 8 | Read data, valid the cycle after the read |
| mem_wr_en | output | 1 | Frame memory write enable |
| mem_waddr | output | 20 | Frame memory write pixel address |
| mem_wdata | output | 8 | Frame memory write data |
| dirty_valid | output | 1 | Modified-region report strobe |
| dirty_start | output | 20 | First modified pixel address |
| dirty_len | output | 6 | Number of modified pixels |

## Verification
The bench targets four failure modes:
- **Overlapping copies with destination one above the source.** A design without the read-to-write forwarding path would read stale memory and shift the old pixels instead of replicating the first one.
- **Sentinel decoding.** A source with only the low 20 bits set must copy from the top pixel. A design that tested too few bits would treat it as a fill.
- **Launches and colour writes made while busy.** A design that failed to ignore these would paint the wrong region or the wrong colour, and its extra or missing report would upset the scoreboard.
- **Runs at both length limits, and runs that cross the top of the 20-bit pixel space.** Wrong length arithmetic or wrong wrap handling would show up as an extra pixel, a missing pixel, or a wrong busy duration.

// File: rtl/fb_blit_pkg.sv
package fb_blit_pkg;

  // Address bit that separates a colour load from an operation launch.
  localparam int unsigned CMD_SEL_BIT = 2;
  // Lowest bus address bit that maps to the destination pixel address.
  localparam int unsigned DST_LSB = 3;

  typedef enum logic {
    OP_COPY = 1'b0,
    OP_FILL = 1'b1
  } blit_op_e;

  // A source field with every bit set selects fill; anything else copies.
  function automatic blit_op_e op_from_src(input logic [23:0] src);
    return (&src) ? OP_FILL : OP_COPY;
  endfunction

endpackage

// File: rtl/fb_blit_regs.sv
module fb_blit_regs
  import fb_blit_pkg::*;
#(
  parameter int unsigned BUS_AW = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PIX_AW = 20,
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned SRC_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              busy,
  output logic              start,
  output blit_op_e          start_op,
  output logic [PIX_AW-1:0] start_dst,
  output logic [PIX_AW-1:0] start_src,
  output logic [LEN_W-1:0]  start_lenm1,
  output logic [PIX_W-1:0]  hold_colour
);

  localparam int unsigned LEN_LSB = SRC_W;
  localparam int unsigned LEN_MSB = SRC_W + LEN_W - 1;
  localparam int unsigned DST_MSB = DST_LSB + PIX_AW - 1;

  logic             is_cmd;
  logic [SRC_W-1:0] src_field;
  logic             unused_bits;

  assign is_cmd    = bus_addr[CMD_SEL_BIT];
  assign src_field = bus_wdata[SRC_W-1:0];

  // Colour holding register: loaded by every colour write, busy or not.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_colour <= '0;
    end else if (bus_wr && !is_cmd) begin
      hold_colour <= bus_wdata[PIX_W-1:0];
    end
  end

  // Launch decode: a launch is accepted only while the engine is idle.
  assign start       = bus_wr && is_cmd && !busy;
  assign start_op    = op_from_src(src_field);
  assign start_dst   = bus_addr[DST_MSB:DST_LSB];
  assign start_src   = src_field[PIX_AW-1:0];
  assign start_lenm1 = bus_wdata[LEN_MSB:LEN_LSB];

  assign unused_bits = ^{bus_addr[BUS_AW-1:DST_MSB+1], bus_addr[1:0],
                         bus_wdata[DATA_W-1:LEN_MSB+1]};

endmodule

// File: rtl/fb_blit_seq.sv
module fb_blit_seq
  import fb_blit_pkg::*;
#(
  parameter int unsigned PIX_AW = 20,
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  blit_op_e          start_op,
  input  logic [PIX_AW-1:0] start_dst,
  input  logic [PIX_AW-1:0] start_src,
  input  logic [LEN_W-1:0]  start_lenm1,
  input  logic [PIX_W-1:0]  start_colour,
  output logic              mem_rd_en,
  output logic [PIX_AW-1:0] mem_raddr,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              mem_wr_en,
  output logic [PIX_AW-1:0] mem_waddr,
  output logic [PIX_W-1:0]  mem_wdata,
  output logic              busy,
  output logic              wr_last
);

  logic              rd_en_q;
  logic [PIX_AW-1:0] raddr_q;
  logic [LEN_W-1:0]  rd_rem_q;
  logic              wr_en_q;
  logic [PIX_AW-1:0] waddr_q;
  logic [LEN_W-1:0]  wr_rem_q;
  blit_op_e          op_q;
  logic [PIX_W-1:0]  colour_q;
  logic              fwd_q;
  logic [PIX_W-1:0]  fwd_data_q;
  logic [PIX_W-1:0]  wdata_c;

  // Write data: the latched colour for fill; for copy, the read data, or
  // the forwarded pixel when last cycle's read hit the pixel being written.
  always_comb begin
    if (op_q == OP_FILL) begin
      wdata_c = colour_q;
    end else if (fwd_q) begin
      wdata_c = fwd_data_q;
    end else begin
      wdata_c = mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_q    <= 1'b0;
      raddr_q    <= '0;
      rd_rem_q   <= '0;
      wr_en_q    <= 1'b0;
      waddr_q    <= '0;
      wr_rem_q   <= '0;
      op_q       <= OP_COPY;
      colour_q   <= '0;
      fwd_q      <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      fwd_q      <= rd_en_q && wr_en_q && (raddr_q == waddr_q);
      fwd_data_q <= wdata_c;
      if (start) begin
        op_q     <= start_op;
        colour_q <= start_colour;
        raddr_q  <= start_src;
        rd_rem_q <= start_lenm1;
        rd_en_q  <= (start_op == OP_COPY);
        waddr_q  <= start_dst;
        wr_rem_q <= start_lenm1;
        wr_en_q  <= (start_op == OP_FILL);
      end else begin
        // Read side (copy only): one source pixel per cycle.
        if (rd_en_q) begin
          if (rd_rem_q == '0) begin
            rd_en_q <= 1'b0;
          end else begin
            raddr_q  <= raddr_q + 1'b1;
            rd_rem_q <= rd_rem_q - 1'b1;
          end
        end
        // Write side.
        if (op_q == OP_FILL) begin
          if (wr_en_q) begin
            if (wr_rem_q == '0) begin
              wr_en_q <= 1'b0;
            end else begin
              waddr_q  <= waddr_q + 1'b1;
              wr_rem_q <= wr_rem_q - 1'b1;
            end
          end
        end else begin
          wr_en_q <= rd_en_q;
          if (wr_en_q) begin
            waddr_q <= waddr_q + 1'b1;
          end
        end
      end
    end
  end

  assign mem_rd_en = rd_en_q;
  assign mem_raddr = raddr_q;
  assign mem_wr_en = wr_en_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_c;
  assign busy      = rd_en_q || wr_en_q;
  assign wr_last   = wr_en_q && ((op_q == OP_FILL) ? (wr_rem_q == '0) : !rd_en_q);

endmodule

// File: rtl/fb_blit_dirty.sv
module fb_blit_dirty #(
  parameter int unsigned PIX_AW = 20,
  parameter int unsigned LEN_W  = 5,
  localparam int unsigned CNT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PIX_AW-1:0] start_dst,
  input  logic [LEN_W-1:0]  start_lenm1,
  input  logic              wr_last,
  output logic              dirty_valid,
  output logic [PIX_AW-1:0] dirty_start,
  output logic [CNT_W-1:0]  dirty_len
);

  logic [PIX_AW-1:0] pend_dst_q;
  logic [CNT_W-1:0]  pend_len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_dst_q  <= '0;
      pend_len_q  <= '0;
      dirty_valid <= 1'b0;
      dirty_start <= '0;
      dirty_len   <= '0;
    end else begin
      if (start) begin
        pend_dst_q <= start_dst;
        pend_len_q <= CNT_W'(start_lenm1) + 1'b1;
      end
      dirty_valid <= wr_last;
      if (wr_last) begin
        dirty_start <= pend_dst_q;
        dirty_len   <= pend_len_q;
      end
    end
  end

endmodule

// File: rtl/fb_blit_engine.sv
module fb_blit_engine
  import fb_blit_pkg::*;
#(
  parameter int unsigned BUS_AW = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PIX_AW = 20,
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned SRC_W  = 24,
  localparam int unsigned CNT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [PIX_AW-1:0] mem_raddr,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              mem_wr_en,
  output logic [PIX_AW-1:0] mem_waddr,
  output logic [PIX_W-1:0]  mem_wdata,
  output logic              dirty_valid,
  output logic [PIX_AW-1:0] dirty_start,
  output logic [CNT_W-1:0]  dirty_len
);

  logic              start;
  blit_op_e          start_op;
  logic [PIX_AW-1:0] start_dst;
  logic [PIX_AW-1:0] start_src;
  logic [LEN_W-1:0]  start_lenm1;
  logic [PIX_W-1:0]  hold_colour;
  logic              wr_last;

  assign bus_rdata = '0;

  fb_blit_regs #(
    .BUS_AW(BUS_AW), .DATA_W(DATA_W), .PIX_AW(PIX_AW),
    .PIX_W(PIX_W), .LEN_W(LEN_W), .SRC_W(SRC_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .start      (start),
    .start_op   (start_op),
    .start_dst  (start_dst),
    .start_src  (start_src),
    .start_lenm1(start_lenm1),
    .hold_colour(hold_colour)
  );

  fb_blit_seq #(
    .PIX_AW(PIX_AW), .PIX_W(PIX_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_op    (start_op),
    .start_dst   (start_dst),
    .start_src   (start_src),
    .start_lenm1 (start_lenm1),
    .start_colour(hold_colour),
    .mem_rd_en   (mem_rd_en),
    .mem_raddr   (mem_raddr),
    .mem_rdata   (mem_rdata),
    .mem_wr_en   (mem_wr_en),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata),
    .busy        (busy),
    .wr_last     (wr_last)
  );

  fb_blit_dirty #(
    .PIX_AW(PIX_AW), .LEN_W(LEN_W)
  ) u_dirty (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_dst  (start_dst),
    .start_lenm1(start_lenm1),
    .wr_last    (wr_last),
    .dirty_valid(dirty_valid),
    .dirty_start(dirty_start),
    .dirty_len  (dirty_len)
  );

endmodule

// File: rtl/fb_blit_checker.sv
module fb_blit_checker #(
  parameter int unsigned BUS_AW = 24,
  parameter int unsigned PIX_AW = 20,
  parameter int unsigned LEN_W  = 5,
  localparam int unsigned CNT_W = LEN_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              busy,
  input logic              mem_rd_en,
  input logic [PIX_AW-1:0] mem_raddr,
  input logic              mem_wr_en,
  input logic [PIX_AW-1:0] mem_waddr,
  input logic              dirty_valid,
  input logic [CNT_W-1:0]  dirty_len
);

  localparam int unsigned MAX_RUN = 1 << LEN_W;

  // R1: a colour load on an idle engine starts nothing.
  a_r1_hold_no_start: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr[2] && !busy) |=> !busy);

  // R2: a launch on an idle engine makes it busy next cycle.
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[2] && !busy) |=> busy);

  // R10: consecutive pixel writes step by one, wrapping in pixel space.
  a_r10_wr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && $past(mem_wr_en)) |-> (mem_waddr == PIX_AW'($past(mem_waddr) + 1'b1)));

  // R6: consecutive source reads ascend by one.
  a_r6_rd_step: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_raddr == PIX_AW'($past(mem_raddr) + 1'b1)));

  // R9: the report follows the final write, with the engine already free.
  a_r9_dirty_after_write: assert property (@(posedge clk) disable iff (rst)
    dirty_valid |-> ($past(mem_wr_en) && !mem_wr_en && !busy));

  // R9: a reported length lies within the legal run range.
  a_r9_dirty_len_range: assert property (@(posedge clk) disable iff (rst)
    dirty_valid |-> (dirty_len != '0 && dirty_len <= CNT_W'(MAX_RUN)));

  // R9: the report is a single-cycle pulse.
  a_r9_dirty_pulse: assert property (@(posedge clk) disable iff (rst)
    dirty_valid |=> !dirty_valid);

endmodule

bind fb_blit_engine fb_blit_checker #(
  .BUS_AW(BUS_AW), .PIX_AW(PIX_AW), .LEN_W(LEN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .busy       (busy),
  .mem_rd_en  (mem_rd_en),
  .mem_raddr  (mem_raddr),
  .mem_wr_en  (mem_wr_en),
  .mem_waddr  (mem_waddr),
  .dirty_valid(dirty_valid),
  .dirty_len  (dirty_len)
);

// File: tb/fb_blit_engine_tb.sv
module fb_blit_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 12;
  localparam int MEM_N      = 1 << MEM_AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        busy;
  logic        mem_rd_en;
  logic [19:0] mem_raddr;
  logic [7:0]  mem_rdata;
  logic        mem_wr_en;
  logic [19:0] mem_waddr;
  logic [7:0]  mem_wdata;
  logic        dirty_valid;
  logic [19:0] dirty_start;
  logic [5:0]  dirty_len;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0]  mem     [MEM_N];
  logic [7:0]  exp_mem [MEM_N];
  logic [7:0]  hold_model = '0;
  logic [19:0] q_start [$];
  logic [5:0]  q_len   [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_blit_engine u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_wr_en(mem_wr_en), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .dirty_valid(dirty_valid), .dirty_start(dirty_start), .dirty_len(dirty_len)
  );

  // Read-first synchronous frame memory model (aliased to 4096 pixels).
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_raddr[MEM_AW-1:0]];
    if (mem_wr_en) mem[mem_waddr[MEM_AW-1:0]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Scoreboard monitor for modified-region reports.
  always @(negedge clk) begin
    if (!rst && dirty_valid) begin
      if (q_start.size() == 0) begin
        check(1'b0, "R9", "unexpected dirty report start", dirty_start, 0);
      end else begin
        logic [19:0] es;
        logic [5:0]  el;
        es = q_start.pop_front();
        el = q_len.pop_front();
        check(dirty_start == es && dirty_len == el, "R9", "dirty start/len",
              {dirty_start, 2'b0, dirty_len}, {es, 2'b0, el});
      end
    end
  end

  task automatic host_write(input logic [23:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic set_colour(input logic [31:0] c);
    host_write(24'h000010, c);
    hold_model = c[7:0];
  endtask

  // Launch an operation and update the reference model for it.
  task automatic issue(input logic [19:0] dst, input logic [23:0] src,
                       input logic [4:0] lm1, input logic [2:0] topb);
    host_write({1'b0, dst, 3'b100}, {topb, lm1, src});
    for (int i = 0; i <= int'(lm1); i++) begin
      logic [19:0] d;
      logic [19:0] s;
      d = dst + 20'(i);
      s = src[19:0] + 20'(i);
      if (&src) exp_mem[d[MEM_AW-1:0]] = hold_model;
      else      exp_mem[d[MEM_AW-1:0]] = exp_mem[s[MEM_AW-1:0]];
    end
    q_start.push_back(dst);
    q_len.push_back(6'(lm1) + 6'd1);
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy && cycles < 100) begin
      cycles++;
      @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_mem(input string tag);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < MEM_N; i++) begin
      if (mem[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) first = 0;
    check(bad == 0, tag, $sformatf("memory mismatch count, first at %0h", first),
          mem[first], exp_mem[first]);
  endtask

  task automatic run_op(input logic [19:0] dst, input logic [23:0] src,
                        input logic [4:0] lm1, input logic [2:0] topb,
                        input string tag);
    int cyc;
    int expc;
    issue(dst, src, lm1, topb);
    expc = (&src) ? int'(lm1) + 1 : int'(lm1) + 2;
    wait_idle(cyc);
    check(cyc == expc, "R11", {"busy duration for ", tag}, cyc, expc);
    check_mem(tag);
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check(busy == 1'b0 && dirty_valid == 1'b0 && mem_wr_en == 1'b0 && mem_rd_en == 1'b0,
          "R2", "reset state busy/dirty/mem enables",
          {busy, dirty_valid, mem_wr_en, mem_rd_en}, 0);
    check(bus_rdata == 32'h0, "R8", "read data after reset", bus_rdata, 0);

    // R1: colour load alone does nothing visible.
    set_colour(32'hDEAD_BE5A);
    check(busy == 1'b0, "R1", "busy after colour load", busy, 0);
    @(negedge clk);
    check_mem("R1");

    // R5 / R3 / R4: fill 8 pixels at 0x100.
    run_op(20'h00100, 24'hFFFFFF, 5'd7, 3'b000, "R5");
    // R4: single-pixel fill, top data bits set (must be ignored).
    set_colour(32'h0000_0011);
    run_op(20'h00200, 24'hFFFFFF, 5'd0, 3'b111, "R4");
    // R4: maximum 32-pixel copy from non-overlapping source.
    run_op(20'h00400, 24'h000300, 5'd31, 3'b101, "R4");
    // R6: forward overlapping copy, destination = source + 1.
    run_op(20'h00501, 24'h000500, 5'd9, 3'b000, "R6");
    // R6: backward overlap, destination = source - 1.
    run_op(20'h005FF, 24'h000600, 5'd15, 3'b000, "R6");
    // R6: low-20-bit all-ones source is a copy from the top pixel, not a fill.
    run_op(20'h00700, 24'h0FFFFF, 5'd2, 3'b000, "R6");
    // R10: fill crossing the top of pixel space.
    set_colour(32'h0000_00C3);
    run_op(20'hFFFFE, 24'hFFFFFF, 5'd3, 3'b000, "R10");
    // R10: source above 20 bits wraps to low pixel space.
    run_op(20'h00800, 24'h100020, 5'd4, 3'b000, "R10");
    // R3: destination from upper bus address bits.
    run_op(20'h00ABC, 24'h000010, 5'd1, 3'b000, "R3");

    // R7: launch while busy is ignored.
    begin
      int cyc;
      set_colour(32'h0000_0077);
      issue(20'h00900, 24'hFFFFFF, 5'd31, 3'b000);
      host_write({1'b0, 20'h00A00, 3'b100}, {3'b000, 5'd7, 24'hFFFFFF});
      check(bus_rdata == 32'h0, "R8", "read data while busy", bus_rdata, 0);
      wait_idle(cyc);
      check_mem("R7");
    end

    // R5: colour load during a running fill does not alter it.
    begin
      int cyc;
      set_colour(32'h0000_0042);
      issue(20'h00B00, 24'hFFFFFF, 5'd15, 3'b000);
      host_write(24'h000020, 32'h0000_00EE);
      wait_idle(cyc);
      check_mem("R5");
      hold_model = 8'hEE;
    end
    run_op(20'h00C00, 24'hFFFFFF, 5'd3, 3'b000, "R5");

    repeat (3) @(negedge clk);
    check(q_start.size() == 0, "R9", "outstanding dirty reports", q_start.size(), 0);
    check(bus_rdata == 32'h0, "R8", "read data at end", bus_rdata, 0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule